// File: doc/BRIEF.md
# Grouped GPIO Pad Configuration Bank

This block holds the configuration of a bank of general-purpose pads and drives the pads from it. Pads are organised in groups of up to fifteen slots, and each group has its own populated count. Every populated pad owns two 32-bit configuration words in a sparse address map, reached over a simple register bus with address, write enable, write data and registered read data.

The first word of a pad holds its driven level, a three-bit direction mode and a four-bit interrupt line selector. It also returns the synchronised input level, which software can read but not write. The second word holds a trigger type and invert controls. The block only stores these interrupt-related fields and exports them for every pad to a separate interrupt block. Output value and output enable of each pad follow from its mode and driven level. Addresses that decode to no populated pad read as zero, and writes to them are dropped.

Top module: `gpio_pad_bank`

## Requirements
- R1: After a synchronous reset every pad has mode 3 and driven level 0, every second word is 0, all output enables, pad outputs, exported fields and the read data are 0, and the first word of a populated pad reads 0x00000300 while its input is low.
- R2: The first word of the pad in group g, slot s sits at byte address BASE_ADDR + 1024*g + 8*s and the second word 4 bytes higher. Only addresses that are multiples of 4 decode.
- R3: The read data is registered. It shows the word addressed in the previous cycle as it stood before any write on that same clock edge, and a write takes effect on the edge where the write enable is high.
- R4: In the first word, bit 1 is the driven level, bits 10:8 the mode and bits 31:28 the interrupt line selector. Bits 27:11 and 7:2 read as zero.
- R5: In the second word, bits 2:0 are the trigger type and bits 7:4 the invert controls. All other bits read as zero.
- R6: In mode 0 (bidirectional) and mode 1 (output only) the pad's output enable is 1 and its output equals the driven level, from the edge that writes the mode.
- R7: In mode 2 (input only), mode 3 (high impedance) and the unused codes 4 to 7, the pad's output enable and output are both 0.
- R8: Bit 0 of the first word is the pad input after two flops. A change at the input is first seen in the second read that follows it, and writes to bit 0 have no effect.
- R9: Slots at or above the group's populated count, groups at or above the group count, gaps, addresses below the base and misaligned addresses all read 0 and ignore writes. Such pads keep output enable, output and exported fields at 0.
- R10: For flat pad index p = 15*g + s, the exports place the selector at irq_sel[4p+3:4p], the trigger at trig_type[3p+2:3p] and the invert controls at inv_ctl[4p+3:4p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the previous cycle's address |
| pad_in | input | NUM_GROUPS*15 | Asynchronous pad input levels |
| pad_out | output | NUM_GROUPS*15 | Pad output values |
| pad_oe | output | NUM_GROUPS*15 | Pad output enables |
| irq_sel | output | 4*NUM_GROUPS*15 | Interrupt line selector per pad |
| trig_type | output | 3*NUM_GROUPS*15 | Trigger type per pad |
| inv_ctl | output | 4*NUM_GROUPS*15 | Invert controls per pad |

## Verification
The bench builds the bank with three groups whose populated counts are 9, 15 and 12, in a 16-bit address space. It therefore reaches a full group next to two partial ones. It also reaches the last populated slot and the first empty slot of a partial group, the gap slot 15 in every group, a fourth group that lies inside the address range but is not built, addresses below the base and misaligned addresses that would alias a real word if alignment were ignored. Long random phases mix valid and invalid accesses with toggling inputs, so that read-during-write ordering and the two-flop input latency are compared against the reference on every clock.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int WORD_W     = 32;
  localparam int FILL_W     = 4;
  localparam int MODE_W     = 3;
  localparam int ISEL_W     = 4;
  localparam int TRIG_W     = 3;
  localparam int INV_W      = 4;
  // first word field positions
  localparam int W0_RX      = 0;
  localparam int W0_TX      = 1;
  localparam int W0_MODE_LO = 8;
  localparam int W0_ISEL_LO = 28;
  // second word field positions
  localparam int W1_TRIG_LO = 0;
  localparam int W1_INV_LO  = 4;
  // byte stride between pads is 1 << SLOT_LG
  localparam int SLOT_LG    = 3;
  localparam int WORD_BIT   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_BIDIR = 3'd0,
    MODE_OUT   = 3'd1,
    MODE_IN    = 3'd2,
    MODE_HIZ   = 3'd3
  } pad_mode_e;

  function automatic logic mode_drives(input logic [MODE_W-1:0] m);
    return (m == MODE_BIDIR) || (m == MODE_OUT);
  endfunction
endpackage

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_pad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4400,
  parameter int NUM_GROUPS = 3,
  parameter logic [NUM_GROUPS*FILL_W-1:0] GROUP_FILL = {4'd12, 4'd15, 4'd9},
  parameter int GROUP_LG = 10,
  parameter int GRP_W = 2,
  parameter int SLOT_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [GRP_W-1:0]  grp,
  output logic [SLOT_W-1:0] slot,
  output logic              word_sel
);
  localparam int GF_W = ADDR_W - GROUP_LG;
  localparam int SF_W = GROUP_LG - SLOT_LG;

  logic [ADDR_W-1:0]   off;
  logic [GROUP_LG-1:0] in_grp;
  logic [GF_W-1:0]     grp_full;
  logic [SF_W-1:0]     slot_full;
  logic [FILL_W-1:0]   fill;
  logic                above, aligned, grp_ok;

  assign off       = addr - BASE_ADDR;
  assign above     = (addr >= BASE_ADDR);
  assign in_grp    = off[GROUP_LG-1:0];
  assign grp_full  = off[ADDR_W-1:GROUP_LG];
  assign slot_full = in_grp[GROUP_LG-1:SLOT_LG];
  assign aligned   = (in_grp[1:0] == 2'b00);
  assign grp_ok    = (grp_full < GF_W'(NUM_GROUPS));

  always_comb begin
    fill = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_full == GF_W'(g)) fill = GROUP_FILL[g*FILL_W +: FILL_W];
    end
  end

  assign hit      = above && aligned && grp_ok && (slot_full < SF_W'(fill));
  assign grp      = grp_full[GRP_W-1:0];
  assign slot     = slot_full[SLOT_W-1:0];
  assign word_sel = in_grp[WORD_BIT];
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pad_in,
  input  logic              wr_w0,
  input  logic              wr_w1,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [ISEL_W-1:0] isel,
  output logic [TRIG_W-1:0] trig,
  output logic [INV_W-1:0]  inv
);
  logic              tx_q, sync1_q, sync2_q, out_q, oe_q;
  logic [MODE_W-1:0] mode_q, new_mode;
  logic [ISEL_W-1:0] isel_q;
  logic [TRIG_W-1:0] trig_q;
  logic [INV_W-1:0]  inv_q;
  logic [1:0]        alive_q;
  logic              unused_wbits;

  assign new_mode     = wdata[W0_MODE_LO +: MODE_W];
  assign unused_wbits = ^{wdata[27:11], wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= 1'b0;
      mode_q  <= MODE_HIZ;
      isel_q  <= '0;
      trig_q  <= '0;
      inv_q   <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      alive_q <= 2'd0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (alive_q != 2'd2) alive_q <= alive_q + 2'd1;
      if (wr_w0) begin
        tx_q   <= wdata[W0_TX];
        mode_q <= new_mode;
        isel_q <= wdata[W0_ISEL_LO +: ISEL_W];
        oe_q   <= mode_drives(new_mode);
        out_q  <= wdata[W0_TX] & mode_drives(new_mode);
      end
      if (wr_w1) begin
        trig_q <= wdata[W1_TRIG_LO +: TRIG_W];
        inv_q  <= wdata[W1_INV_LO +: INV_W];
      end
    end
  end

  always_comb begin
    word0 = '0;
    word0[W0_RX] = sync2_q;
    word0[W0_TX] = tx_q;
    word0[W0_MODE_LO +: MODE_W] = mode_q;
    word0[W0_ISEL_LO +: ISEL_W] = isel_q;
    word1 = '0;
    word1[W1_TRIG_LO +: TRIG_W] = trig_q;
    word1[W1_INV_LO +: INV_W] = inv_q;
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;
  assign isel    = isel_q;
  assign trig    = trig_q;
  assign inv     = inv_q;

  // R6: a driving mode enables the pad on the next edge with the written level
  a_r6_drive_after_write: assert property (@(posedge clk) disable iff (rst)
    (wr_w0 && (wdata[W0_MODE_LO +: MODE_W] < 3'd2)) |=> (pad_oe && (pad_out == $past(wdata[W0_TX]))));

  // R7: a releasing mode drops output enable and output on the next edge
  a_r7_release_after_write: assert property (@(posedge clk) disable iff (rst)
    (wr_w0 && (wdata[W0_MODE_LO +: MODE_W] >= 3'd2)) |=> (!pad_oe && !pad_out));

  // R8: status bit is the input two edges back
  a_r8_rx_two_stage: assert property (@(posedge clk) disable iff (rst)
    (alive_q == 2'd2) |-> (word0[W0_RX] == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4400,
  parameter int NUM_GROUPS = 3,
  parameter int GROUP_SLOTS = 15,
  parameter logic [NUM_GROUPS*FILL_W-1:0] GROUP_FILL = {4'd12, 4'd15, 4'd9},
  parameter int GROUP_LG = 10,
  localparam int NPADS = NUM_GROUPS * GROUP_SLOTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  input  logic [NPADS-1:0]        pad_in,
  output logic [NPADS-1:0]        pad_out,
  output logic [NPADS-1:0]        pad_oe,
  output logic [NPADS*ISEL_W-1:0] irq_sel,
  output logic [NPADS*TRIG_W-1:0] trig_type,
  output logic [NPADS*INV_W-1:0]  inv_ctl
);
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int SLOT_W = (GROUP_SLOTS > 1) ? $clog2(GROUP_SLOTS) : 1;
  localparam int PAD_W  = (NPADS > 1) ? $clog2(NPADS) : 1;

  logic              dec_hit, dec_word;
  logic [GRP_W-1:0]  dec_grp;
  logic [SLOT_W-1:0] dec_slot;
  logic [PAD_W-1:0]  pad_idx;
  logic [NPADS-1:0]  pad_sel;
  logic [NPADS-1:0]  unused_pads;
  logic [WORD_W-1:0] w0_arr [NPADS];
  logic [WORD_W-1:0] w1_arr [NPADS];
  logic [WORD_W-1:0] rd_next;

  gpio_pad_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_GROUPS(NUM_GROUPS),
    .GROUP_FILL(GROUP_FILL), .GROUP_LG(GROUP_LG), .GRP_W(GRP_W), .SLOT_W(SLOT_W)
  ) u_dec (
    .addr(bus_addr), .hit(dec_hit), .grp(dec_grp), .slot(dec_slot), .word_sel(dec_word)
  );

  assign pad_idx = PAD_W'(dec_grp) * PAD_W'(GROUP_SLOTS) + PAD_W'(dec_slot);

  always_comb begin
    pad_sel = '0;
    if (dec_hit) pad_sel[pad_idx] = 1'b1;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int FILL = int'(GROUP_FILL[g*FILL_W +: FILL_W]);
    for (genvar s = 0; s < GROUP_SLOTS; s++) begin : g_slot
      localparam int P = g * GROUP_SLOTS + s;
      if (s < FILL) begin : g_pad
        gpio_pad_cell u_cell (
          .clk(clk), .rst(rst), .pad_in(pad_in[P]),
          .wr_w0(bus_we && pad_sel[P] && !dec_word),
          .wr_w1(bus_we && pad_sel[P] && dec_word),
          .wdata(bus_wdata), .word0(w0_arr[P]), .word1(w1_arr[P]),
          .pad_out(pad_out[P]), .pad_oe(pad_oe[P]),
          .isel(irq_sel[P*ISEL_W +: ISEL_W]),
          .trig(trig_type[P*TRIG_W +: TRIG_W]),
          .inv(inv_ctl[P*INV_W +: INV_W])
        );
        assign unused_pads[P] = 1'b0;
      end else begin : g_empty
        assign w0_arr[P] = '0;
        assign w1_arr[P] = '0;
        assign pad_out[P] = 1'b0;
        assign pad_oe[P] = 1'b0;
        assign irq_sel[P*ISEL_W +: ISEL_W] = '0;
        assign trig_type[P*TRIG_W +: TRIG_W] = '0;
        assign inv_ctl[P*INV_W +: INV_W] = '0;
        assign unused_pads[P] = pad_in[P] ^ pad_sel[P];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (dec_hit) rd_next = dec_word ? w1_arr[pad_idx] : w0_arr[pad_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R9: an access that decodes to no pad returns zero on the next cycle
  a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |=> (bus_rdata == '0));

  // R9: a write that decodes to no pad leaves every pad-facing output unchanged
  a_r9_miss_write_no_change: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !dec_hit) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(irq_sel)
                              && $stable(trig_type) && $stable(inv_ctl)));
endmodule

// File: tb/tb_gpio_pad_bank.sv
`timescale 1ns/1ps
module tb_gpio_pad_bank;
  localparam int NG = 3;
  localparam int SL = 15;
  localparam int NP = NG * SL;
  localparam logic [15:0] BASE = 16'h4400;
  int fill_of [NG] = '{9, 15, 12};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP*4-1:0] irq_sel, inv_ctl;
  logic [NP*3-1:0] trig_type;

  gpio_pad_bank #(
    .ADDR_W(16), .BASE_ADDR(BASE), .NUM_GROUPS(NG), .GROUP_SLOTS(SL),
    .GROUP_FILL({4'd12, 4'd15, 4'd9}), .GROUP_LG(10)
  ) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_sel(irq_sel), .trig_type(trig_type), .inv_ctl(inv_ctl)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference state
  int m_tx [NP];
  int m_mode [NP];
  int m_isel [NP];
  int m_trig [NP];
  int m_inv [NP];
  bit s1 [NP];
  bit s2 [NP];
  logic [31:0] exp_rd = '0;

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] adr(input int g, input int s, input int w);
    return 16'(int'(BASE) + 1024 * g + 8 * s + 4 * w);
  endfunction

  function automatic void decode(input logic [15:0] a, output bit v, output int idx, output int word);
    int off, g, rem, s;
    v = 0; idx = 0; word = 0;
    if (a < BASE) return;
    off = int'(a) - int'(BASE);
    if (off % 4 != 0) return;
    g = off / 1024; rem = off % 1024; s = rem / 8; word = (rem % 8) / 4;
    if (g < NG && s < fill_of[g]) begin v = 1; idx = g * SL + s; end
  endfunction

  function automatic logic [31:0] rdval(input int idx, input int word);
    if (word == 0)
      return (32'(m_isel[idx]) << 28) | (32'(m_mode[idx]) << 8) | (32'(m_tx[idx]) << 1) | 32'(s2[idx]);
    return (32'(m_inv[idx]) << 4) | 32'(m_trig[idx]);
  endfunction

  always @(posedge clk) begin
    bit v; int idx, word;
    cmp_en = 1;
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_tx[p] = 0; m_mode[p] = 3; m_isel[p] = 0; m_trig[p] = 0; m_inv[p] = 0;
        s1[p] = 0; s2[p] = 0;
      end
      exp_rd = '0;
    end else begin
      decode(bus_addr, v, idx, word);
      exp_rd = v ? rdval(idx, word) : 32'h0;
      for (int p = 0; p < NP; p++) begin s2[p] = s1[p]; s1[p] = pad_in[p]; end
      if (bus_we && v) begin
        if (word == 0) begin
          m_tx[idx] = int'(bus_wdata[1]);
          m_mode[idx] = int'(bus_wdata[10:8]);
          m_isel[idx] = int'(bus_wdata[31:28]);
        end else begin
          m_trig[idx] = int'(bus_wdata[2:0]);
          m_inv[idx] = int'(bus_wdata[7:4]);
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    logic [NP-1:0] e_oe, e_out;
    logic [NP*4-1:0] e_isel, e_inv;
    logic [NP*3-1:0] e_trig;
    if (cmp_en && !done) begin
      for (int p = 0; p < NP; p++) begin
        e_oe[p] = (m_mode[p] <= 1);
        e_out[p] = e_oe[p] && (m_tx[p] != 0);
        e_isel[p*4 +: 4] = 4'(m_isel[p]);
        e_inv[p*4 +: 4] = 4'(m_inv[p]);
        e_trig[p*3 +: 3] = 3'(m_trig[p]);
      end
      chk("R3 read data", bus_rdata, exp_rd);
      chk("R6 output enable", pad_oe, e_oe);
      chk("R7 pad output", pad_out, e_out);
      chk("R10 irq_sel", irq_sel, e_isel);
      chk("R10 trig_type", trig_type, e_trig);
      chk("R10 inv_ctl", inv_ctl, e_inv);
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 oe after reset", pad_oe, '0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq_sel after reset", irq_sel, '0);
    bus_rd(adr(1, 3, 0), d); chk("R1 word0 reset", d, 32'h0000_0300);
    bus_rd(adr(1, 3, 1), d); chk("R1 word1 reset", d, 32'h0);

    // R2 R4 R6 R10: group 0 slot 0 output mode
    bus_wr(adr(0, 0, 0), 32'hA000_0102);
    bus_rd(adr(0, 0, 0), d); chk("R2 word0 readback", d, 32'hA000_0102);
    chk("R6 pad0 oe", pad_oe[0], 1'b1);
    chk("R6 pad0 out", pad_out[0], 1'b1);
    chk("R10 pad0 selector", irq_sel[3:0], 4'hA);

    // R4 R8 R7: all ones into group 1 slot 14 (p=29)
    bus_wr(adr(1, 14, 0), 32'hFFFF_FFFF);
    bus_rd(adr(1, 14, 0), d); chk("R4 R8 word0 masked", d, 32'hF000_0702);
    chk("R7 mode 7 oe", pad_oe[29], 1'b0);
    chk("R7 mode 7 out", pad_out[29], 1'b0);
    bus_wr(adr(1, 14, 1), 32'hFFFF_FFFF);
    bus_rd(adr(1, 14, 1), d); chk("R5 word1 masked", d, 32'h0000_00F7);
    chk("R10 trig p29", trig_type[29*3 +: 3], 3'h7);
    chk("R10 inv p29", inv_ctl[29*4 +: 4], 4'hF);

    // R6 R7: last populated slot of group 2 (p=41)
    bus_wr(adr(2, 11, 0), 32'h0000_0000);
    chk("R6 bidir oe", pad_oe[41], 1'b1); chk("R6 bidir low", pad_out[41], 1'b0);
    bus_wr(adr(2, 11, 0), 32'h0000_0002);
    chk("R6 bidir high", pad_out[41], 1'b1);
    bus_wr(adr(2, 11, 0), 32'h0000_0202);
    chk("R7 input oe", pad_oe[41], 1'b0); chk("R7 input out", pad_out[41], 1'b0);
    bus_wr(adr(2, 11, 0), 32'h0000_0102);
    bus_wr(adr(2, 11, 0), 32'h0000_0402);
    chk("R7 code 4 oe", pad_oe[41], 1'b0);

    // R9 invalid accesses
    bus_wr(16'h4402, 32'h0);
    bus_rd(adr(0, 0, 0), d); chk("R9 misaligned write ignored", d, 32'hA000_0102);
    bus_rd(16'h4402, d); chk("R9 misaligned read", d, 32'h0);
    bus_wr(adr(0, 9, 0), 32'h0000_0102);
    bus_rd(adr(0, 9, 0), d); chk("R9 empty slot read", d, 32'h0);
    chk("R9 empty slot oe", pad_oe[9], 1'b0);
    bus_wr(adr(2, 12, 0), 32'hF000_0102);
    chk("R9 empty slot g2 oe", pad_oe[42], 1'b0);
    chk("R9 empty slot g2 sel", irq_sel[42*4 +: 4], 4'h0);
    bus_rd(adr(3, 0, 0), d); chk("R9 group beyond count", d, 32'h0);
    bus_rd(16'h43FC, d); chk("R9 below base", d, 32'h0);
    bus_rd(adr(1, 15, 0), d); chk("R9 gap slot", d, 32'h0);

    // R8 two-flop input latency on p=15
    @(negedge clk); pad_in[15] = 1'b1;
    bus_rd(adr(1, 0, 0), d); chk("R8 first read old level", d, 32'h0000_0300);
    bus_rd(adr(1, 0, 0), d); chk("R8 second read new level", d, 32'h0000_0301);
    bus_wr(adr(1, 0, 0), 32'h0000_0300);
    bus_rd(adr(1, 0, 0), d); chk("R8 write to bit0 ignored", d, 32'h0000_0301);

    // R3 read during write returns the old value
    @(negedge clk); bus_addr = adr(0, 0, 0); bus_wdata = 32'h0000_0102; bus_we = 1'b1;
    @(negedge clk); d = bus_rdata; bus_we = 1'b0;
    chk("R3 read during write old", d, 32'hA000_0102);
    bus_rd(adr(0, 0, 0), d); chk("R3 read after write new", d, 32'h0000_0102);

    // random mix of valid and invalid traffic
    for (int i = 0; i < 4000; i++) begin
      int g, s, w, mis;
      @(negedge clk);
      g = int'($urandom % 4); s = int'($urandom % 16); w = int'($urandom % 2);
      mis = (($urandom % 8) == 0) ? int'($urandom % 4) : 0;
      bus_addr = 16'(int'(BASE) + 1024 * g + 8 * s + 4 * w + mis);
      if (($urandom % 32) == 0) bus_addr = 16'($urandom);
      bus_wdata = $urandom;
      bus_we = ($urandom % 2) == 1;
      pad_in = {$urandom, $urandom};
    end
    @(negedge clk); bus_we = 1'b0;

    // R1 reset again after traffic
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 oe after second reset", pad_oe, '0);
    chk("R1 trig after second reset", trig_type, '0);
    pad_in = '0;
    repeat (3) @(negedge clk);
    bus_rd(adr(0, 0, 0), d); chk("R1 word0 after second reset", d, 32'h0000_0300);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule